// File: doc/BRIEF.md
# Vectored Interrupt Priority Tracker

This block keeps the state of a bank of numbered interrupt vectors for one processor. It holds three bit vectors of one bit per vector: requests waiting to be taken, vectors now being serviced, and the trigger kind recorded for each vector. Interrupt sources post a vector number with a level-or-edge flag. The block raises an interrupt request toward the processor when a waiting vector outranks every vector in service. Priority goes to the lowest vector number.

The processor takes an interrupt with a one-cycle acknowledge strobe. In the same cycle the block returns the winning vector, and on the clock edge it moves that vector from waiting to in service. An end-of-service strobe retires the best vector in service. A task-priority value written from outside is merged with the class of the best in-service vector to give a processor-priority output. An external register front end reads any 32-bit word of the three bit vectors through a select and word index.

Top module: `vec_prio_tracker`

## Requirements
- R1: After reset the three bit vectors and the task priority are zero. irq_o is 0, ppr_o is 0 and every readback word is 0.
- R2: A set request (set_valid_i) for vector v sets the waiting bit in readback word v[7:5], bit v[4:0], with rd_sel_i = 0. The change is visible after the next clock edge.
- R3: A set request writes the trigger bit of v (rd_sel_i = 2) to set_level_i: 1 for level, 0 for edge.
- R4: While ack_i is high with enable_i high and at least one request waiting, ack_hit_o is 1 and ack_vec_o gives the lowest-numbered waiting vector in the same cycle. At the clock edge that vector leaves the waiting set and enters the in-service set (rd_sel_i = 1).
- R5: While enable_i is low or nothing is waiting, ack_hit_o is 0 during an acknowledge and no bit vector changes.
- R6: irq_o is 1 exactly when some request is waiting and either nothing is in service or the lowest waiting number is strictly below the lowest in-service number.
- R7: eoi_i clears the lowest-numbered in-service bit. With nothing in service it changes nothing.
- R8: With t the task priority (loaded by tpr_we_i) and c bits [7:4] of the lowest in-service vector (0 when none is in service), ppr_o equals t when t[7:4] >= c and equals c shifted left by 4 otherwise.
- R9: When a set request and an acknowledge fall in the same cycle, the acknowledge picks its winner from the waiting set as it was before the set, and the set also takes effect at that edge.
- R10: rd_sel_i = 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Global enable; gates acknowledgement |
| set_valid_i | input | 1 | Post a request this cycle |
| set_vec_i | input | 8 | Vector number of the request |
| set_level_i | input | 1 | Trigger kind: 1 level, 0 edge |
| ack_i | input | 1 | Acknowledge strobe from the processor |
| ack_hit_o | output | 1 | Acknowledge found a vector |
| ack_vec_o | output | 8 | Winning vector number |
| eoi_i | input | 1 | End-of-service strobe |
| tpr_we_i | input | 1 | Load task priority |
| tpr_wdata_i | input | 8 | Task priority value |
| ppr_o | output | 8 | Processor priority |
| irq_o | output | 1 | Interrupt request to the processor |
| rd_sel_i | input | 2 | Readback select: 0 waiting, 1 in service, 2 trigger, 3 zero |
| rd_word_i | input | 3 | Readback word index |
| rd_data_o | output | 32 | Readback word |

## Verification
The hardest case to reach is nested service, where a low-numbered vector preempts one already in service. The in-service set must then hold two vectors, so that each end-of-service strobe retires the right one and the processor priority follows the class of whichever remains. The stimulus gets there by taking a high-numbered vector first, keeping a still higher number waiting so that irq_o stays low, and then posting a lower number so that irq_o rises again and a second acknowledge nests it. The cycle that combines a set with an acknowledge is driven on purpose, while the only waiting vector ranks below the one being posted.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_SERV = 2'd1,
    SEL_TRIG = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/vpt_prio_enc.sv
// Lowest set index across WORDS words of WORD_W bits.
module vpt_prio_enc #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int NUM   = WORDS * WORD_W,
  localparam int IDX_W = $clog2(NUM),
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic [NUM-1:0]   vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  function automatic logic [BIT_W-1:0] low_bit(input logic [WORD_W-1:0] w);
    logic [BIT_W-1:0] r;
    r = '0;
    for (int b = WORD_W - 1; b >= 0; b--) begin
      if (w[b]) r = BIT_W'(b);
    end
    return r;
  endfunction

  logic [WORDS-1:0] w_any;
  logic [BIT_W-1:0] w_idx [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign w_any[w] = |vec_i[w*WORD_W +: WORD_W];
    assign w_idx[w] = low_bit(vec_i[w*WORD_W +: WORD_W]);
  end

  always_comb begin
    any_o = |w_any;
    idx_o = '0;
    for (int w = WORDS - 1; w >= 0; w--) begin
      if (w_any[w]) idx_o = IDX_W'(w * WORD_W) + IDX_W'(w_idx[w]);
    end
  end
endmodule

// File: rtl/vpt_ppr.sv
module vpt_ppr #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4
) (
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             isr_any_i,
  input  logic [VEC_W-1:0] isr_idx_i,
  output logic [VEC_W-1:0] ppr_o
);
  logic [CLS_W-1:0] isr_cls, tpr_cls;

  assign isr_cls = isr_any_i ? isr_idx_i[VEC_W-1 -: CLS_W] : '0;
  assign tpr_cls = tpr_i[VEC_W-1 -: CLS_W];
  assign ppr_o   = (tpr_cls >= isr_cls) ? tpr_i : {isr_cls, {(VEC_W-CLS_W){1'b0}}};
endmodule

// File: rtl/vec_prio_tracker.sv
module vec_prio_tracker #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  parameter int CLS_W  = 4,
  localparam int NUM_VEC = WORDS * WORD_W,
  localparam int VEC_W   = $clog2(NUM_VEC),
  localparam int WSEL_W  = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              set_valid_i,
  input  logic [VEC_W-1:0]  set_vec_i,
  input  logic              set_level_i,
  input  logic              ack_i,
  output logic              ack_hit_o,
  output logic [VEC_W-1:0]  ack_vec_o,
  input  logic              eoi_i,
  input  logic              tpr_we_i,
  input  logic [VEC_W-1:0]  tpr_wdata_i,
  output logic [VEC_W-1:0]  ppr_o,
  output logic              irq_o,
  input  logic [1:0]        rd_sel_i,
  input  logic [WSEL_W-1:0] rd_word_i,
  output logic [WORD_W-1:0] rd_data_o
);
  import vpt_pkg::*;

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [VEC_W-1:0]   tpr_q;

  logic               irr_any, isr_any;
  logic [VEC_W-1:0]   irr_idx, isr_idx;
  logic [NUM_VEC-1:0] set_mask, ack_mask, eoi_mask;

  vpt_prio_enc #(.WORDS(WORDS), .WORD_W(WORD_W)) u_irr_enc (
    .vec_i(irr_q), .any_o(irr_any), .idx_o(irr_idx)
  );

  vpt_prio_enc #(.WORDS(WORDS), .WORD_W(WORD_W)) u_isr_enc (
    .vec_i(isr_q), .any_o(isr_any), .idx_o(isr_idx)
  );

  vpt_ppr #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_ppr (
    .tpr_i(tpr_q), .isr_any_i(isr_any), .isr_idx_i(isr_idx), .ppr_o(ppr_o)
  );

  assign ack_hit_o = ack_i & enable_i & irr_any;
  assign ack_vec_o = ack_hit_o ? irr_idx : '0;
  assign irq_o     = irr_any & (~isr_any | (irr_idx < isr_idx));

  assign set_mask = set_valid_i ? (NUM_VEC'(1) << set_vec_i) : '0;
  assign ack_mask = ack_hit_o ? (NUM_VEC'(1) << irr_idx) : '0;
  assign eoi_mask = (eoi_i & isr_any) ? (NUM_VEC'(1) << isr_idx) : '0;

  // acknowledge sees the pre-set waiting set; set lands on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
      tpr_q <= '0;
    end else begin
      irr_q <= (irr_q & ~ack_mask) | set_mask;
      isr_q <= (isr_q & ~eoi_mask) | ack_mask;
      if (set_valid_i) tmr_q[set_vec_i] <= set_level_i;
      if (tpr_we_i) tpr_q <= tpr_wdata_i;
    end
  end

  always_comb begin
    unique case (rd_sel_e'(rd_sel_i))
      SEL_PEND: rd_data_o = irr_q[rd_word_i*WORD_W +: WORD_W];
      SEL_SERV: rd_data_o = isr_q[rd_word_i*WORD_W +: WORD_W];
      SEL_TRIG: rd_data_o = tmr_q[rd_word_i*WORD_W +: WORD_W];
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/vpt_chk.sv
module vpt_chk #(
  parameter int NUM_VEC = 256,
  parameter int VEC_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               enable_i,
  input logic               set_valid_i,
  input logic [VEC_W-1:0]   set_vec_i,
  input logic               ack_i,
  input logic               ack_hit_o,
  input logic [VEC_W-1:0]   ack_vec_o,
  input logic               eoi_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   ppr_o,
  input logic [NUM_VEC-1:0] irr_q,
  input logic [NUM_VEC-1:0] isr_q,
  input logic [VEC_W-1:0]   tpr_q
);
  logic [VEC_W-1:0] set_vec_d, ack_vec_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_vec_d <= '0;
      ack_vec_d <= '0;
    end else begin
      set_vec_d <= set_vec_i;
      ack_vec_d <= ack_vec_o;
    end
  end

  // R2
  set_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_valid_i |=> irr_q[set_vec_d]);

  // R4
  ack_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_hit_o |=> isr_q[ack_vec_d]);

  // R5
  ack_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !enable_i) |-> !ack_hit_o);

  // R6
  irq_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irr_q != '0));

  // R7
  eoi_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && isr_q == '0 && !ack_hit_o) |=> isr_q == '0);

  // R8
  ppr_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_o[VEC_W-1 -: 4] >= tpr_q[VEC_W-1 -: 4]);
endmodule

bind vec_prio_tracker vpt_chk #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
  .set_valid_i(set_valid_i), .set_vec_i(set_vec_i), .ack_i(ack_i),
  .ack_hit_o(ack_hit_o), .ack_vec_o(ack_vec_o), .eoi_i(eoi_i),
  .irq_o(irq_o), .ppr_o(ppr_o), .irr_q(irr_q), .isr_q(isr_q), .tpr_q(tpr_q)
);

// File: tb/sim_vec_prio_tracker.sv
`timescale 1ns/1ps
module sim_vec_prio_tracker;
  localparam int HALF = 10;

  logic        clk_i = 0, rst_ni = 0;
  logic        enable_i = 0, set_valid_i = 0, set_level_i = 0, ack_i = 0;
  logic [7:0]  set_vec_i = 0, tpr_wdata_i = 0;
  logic        eoi_i = 0, tpr_we_i = 0;
  logic [1:0]  rd_sel_i = 0;
  logic [2:0]  rd_word_i = 0;
  logic        ack_hit_o, irq_o;
  logic [7:0]  ack_vec_o, ppr_o;
  logic [31:0] rd_data_o;

  int checks = 0, failures = 0;

  typedef struct { logic hit; logic [7:0] vec; string tag; } ack_exp_t;
  ack_exp_t exp_q [$];

  always #HALF clk_i = ~clk_i;

  vec_prio_tracker u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
    set_valid_i = 0; ack_i = 0; eoi_i = 0; tpr_we_i = 0;
  endtask

  task automatic post(input logic [7:0] v, input logic lvl);
    set_vec_i = v; set_level_i = lvl; set_valid_i = 1;
  endtask

  task automatic ack(input logic hit, input logic [7:0] v, input string tag);
    ack_exp_t e;
    e.hit = hit; e.vec = v; e.tag = tag;
    exp_q.push_back(e);
    ack_i = 1;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [2:0] w, output logic [31:0] d);
    rd_sel_i = sel; rd_word_i = w; #1; d = rd_data_o;
  endtask

  // monitor: compares acknowledge responses against the scoreboard
  always @(negedge clk_i) begin
    if (ack_i) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R4 unexpected acknowledge actual=1 expected=0");
      end else begin
        ack_exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " hit"}, 32'(ack_hit_o), 32'(e.hit));
        if (e.hit) check({e.tag, " vec"}, 32'(ack_vec_o), 32'(e.vec));
      end
    end
  end

  initial begin
    #(2 * HALF * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    #5;
    // R1 reset state
    check("R1 irq", 32'(irq_o), 0);
    check("R1 ppr", 32'(ppr_o), 0);
    for (int s = 0; s < 3; s++) begin
      for (int w = 0; w < 8; w++) begin
        rd(2'(s), 3'(w), d);
        check("R1 word", d, 0);
      end
    end
    @(negedge clk_i); rst_ni = 1;
    @(posedge clk_i); #1;
    enable_i = 1;

    // R2 R3 level request on 40
    post(8'd40, 1'b1); step();
    rd(2'd0, 3'd1, d); check("R2 pend 40", d, 32'h100);
    rd(2'd2, 3'd1, d); check("R3 trig level", d, 32'h100);
    check("R6 irq idle", 32'(irq_o), 1);
    post(8'd40, 1'b0); step();
    rd(2'd2, 3'd1, d); check("R3 trig edge", d, 0);
    post(8'd200, 1'b0); step();
    rd(2'd0, 3'd6, d); check("R2 pend 200", d, 32'h100);

    // R4 take 40
    ack(1'b1, 8'd40, "R4 ack40"); step();
    rd(2'd1, 3'd1, d); check("R4 serv 40", d, 32'h100);
    rd(2'd0, 3'd1, d); check("R4 pend cleared", d, 0);
    check("R6 irq lower rank", 32'(irq_o), 0);
    check("R8 ppr class", 32'(ppr_o), 32'h20);
    tpr_wdata_i = 8'h35; tpr_we_i = 1; step();
    check("R8 ppr tpr", 32'(ppr_o), 32'h35);
    tpr_wdata_i = 8'h10; tpr_we_i = 1; step();
    check("R8 ppr class wins", 32'(ppr_o), 32'h20);

    // nested: 10 preempts 40
    post(8'd10, 1'b0); step();
    check("R6 irq preempt", 32'(irq_o), 1);
    ack(1'b1, 8'd10, "R4 ack10"); step();
    rd(2'd1, 3'd0, d); check("R4 serv 10", d, 32'h400);
    check("R8 ppr nested", 32'(ppr_o), 32'h10);
    eoi_i = 1; step();
    rd(2'd1, 3'd0, d); check("R7 eoi 10", d, 0);
    rd(2'd1, 3'd1, d); check("R7 keep 40", d, 32'h100);
    check("R8 ppr after eoi", 32'(ppr_o), 32'h20);
    eoi_i = 1; step();
    rd(2'd1, 3'd1, d); check("R7 eoi 40", d, 0);
    eoi_i = 1; step();
    rd(2'd0, 3'd6, d); check("R7 empty eoi pend", d, 32'h100);
    rd(2'd1, 3'd6, d); check("R7 empty eoi serv", d, 0);

    // R5 disabled acknowledge
    enable_i = 0;
    ack(1'b0, 8'd0, "R5 disabled"); step();
    rd(2'd0, 3'd6, d); check("R5 pend kept", d, 32'h100);
    rd(2'd1, 3'd6, d); check("R5 serv kept", d, 0);
    enable_i = 1;

    // R9 set and acknowledge together
    post(8'd5, 1'b1); ack(1'b1, 8'd200, "R9 ack old"); step();
    rd(2'd0, 3'd0, d); check("R9 set landed", d, 32'h20);
    rd(2'd0, 3'd6, d); check("R9 200 taken", d, 0);
    rd(2'd1, 3'd6, d); check("R9 200 serv", d, 32'h100);
    check("R6 irq 5 under 200", 32'(irq_o), 1);
    ack(1'b1, 8'd5, "R4 ack5"); step();
    check("R8 ppr class0", 32'(ppr_o), 32'h10);
    ack(1'b0, 8'd0, "R5 empty"); step();
    rd(2'd1, 3'd0, d); check("R5 empty serv", d, 32'h20);
    check("R6 irq none", 32'(irq_o), 0);
    rd(2'd3, 3'd0, d); check("R10 zero sel", d, 0);

    step();
    check("R4 scoreboard drained", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule